// File: doc/BRIEF.md
# Width-Merging General-Purpose Register File

This block is a bank of sixteen 64-bit general-purpose registers in which every access names an operand size as well as a register. A write supplies an index, a size code and data, and the block merges that data into the stored word by fixed rules. A full-width write replaces the whole word. A 32-bit write fills the low half and clears the upper half. A 16-bit or 8-bit write replaces only its own field and leaves every other bit alone.

There are two read ports. Each one returns the selected register already cut to the requested size and zero-extended to 64 bits. The "high byte" size refers to bits 15:8 and exists only for the four lowest-numbered registers. A high-byte access to any other register is refused and flagged, on the write port and on each read port.

Writes take effect on the rising clock edge. Reads are combinational and have no write-to-read forwarding.

Top module: `subreg_regfile`

## Requirements
- R1: An active-low asynchronous reset clears all registers to zero.
- R2: Size code 3'b000 (full) writes all 64 bits at the rising edge. A read in the same cycle as that write returns the old contents, and the new value is readable in the next cycle.
- R3: Size code 3'b001 (32-bit) stores wr_data[31:0] in bits 31:0 and forces bits 63:32 to zero, whatever the upper data bits hold.
- R4: Size code 3'b010 (16-bit) stores wr_data[15:0] in bits 15:0 and keeps bits 63:16.
- R5: Size code 3'b011 (low byte) stores wr_data[7:0] in bits 7:0 and keeps bits 63:8.
- R6: Size code 3'b100 (high byte) stores wr_data[7:0] in bits 15:8 and keeps all other bits. It is legal only for indices 0 to 3.
- R7: A write with size 3'b100 to an index of 4 or more, or with any size code from 3'b101 to 3'b111, raises wr_illegal in the same cycle while wr_en is high, and leaves the register unchanged.
- R8: A legal read returns the requested field zero-extended to 64 bits, as follows:
  - full: bits 63:0.
  - 32-bit: bits 31:0.
  - 16-bit: bits 15:0.
  - low byte: bits 7:0.
  - high byte: stored bits 15:8, returned in result bits 7:0.
- R9: A read under the same illegal conditions as R7 raises that port's illegal flag and returns zero data.
- R10: The two read ports work independently and can address any registers at any sizes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 3 | Write size code |
| wr_data | input | 64 | Write data, low-aligned |
| wr_illegal | output | 1 | Refused write flag |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_size | input | 3 | Read port 0 size code |
| rd0_data | output | 64 | Read port 0 sliced, zero-extended result |
| rd0_illegal | output | 1 | Read port 0 refused-access flag |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_size | input | 3 | Read port 1 size code |
| rd1_data | output | 64 | Read port 1 sliced, zero-extended result |
| rd1_illegal | output | 1 | Read port 1 refused-access flag |

## Verification
The bench builds the block with its default parameters: sixteen 64-bit registers, of which the first four have a high byte. With these values the index boundary between 3 and 4 and the top index 15 are both reachable, so the high-byte refusal can be tested right at its edge. The full 64-bit width also makes the upper-half clearing of 32-bit writes observable. A pseudo-random phase then mixes all eight size codes on the write port and both read ports against a reference model of the merge rules.

// File: rtl/subreg_pkg.sv
package subreg_pkg;

    typedef enum logic [2:0] {
        SZ_FULL    = 3'b000,
        SZ_WORD32  = 3'b001,
        SZ_HALF16  = 3'b010,
        SZ_BYTE_LO = 3'b011,
        SZ_BYTE_HI = 3'b100
    } opsize_e;

    localparam int SIZE_W = 3;

endpackage

// File: rtl/subreg_legal_chk.sv
module subreg_legal_chk
    import subreg_pkg::*;
#(
    parameter int NUM_REGS       = 16,
    parameter int HIGH_BYTE_REGS = 4,
    localparam int IDX_W         = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [SIZE_W-1:0] size,
    output logic              bad
);

    always_comb begin
        bad = 1'b0;
        if (size > SZ_BYTE_HI) begin
            bad = 1'b1;
        end else if (size == SZ_BYTE_HI && int'(idx) >= HIGH_BYTE_REGS) begin
            bad = 1'b1;
        end
    end

endmodule

// File: rtl/subreg_merge.sv
module subreg_merge
    import subreg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   old_val,
    input  logic [SIZE_W-1:0] size,
    input  logic [XLEN-1:0]   data,
    output logic [XLEN-1:0]   new_val
);

    always_comb begin
        case (size)
            SZ_FULL:    new_val = data;
            SZ_WORD32:  new_val = {{(XLEN-32){1'b0}}, data[31:0]};
            SZ_HALF16:  new_val = {old_val[XLEN-1:16], data[15:0]};
            SZ_BYTE_LO: new_val = {old_val[XLEN-1:8], data[7:0]};
            SZ_BYTE_HI: new_val = {old_val[XLEN-1:16], data[7:0], old_val[7:0]};
            default:    new_val = old_val;
        endcase
    end

endmodule

// File: rtl/subreg_slice.sv
module subreg_slice
    import subreg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   word,
    input  logic [SIZE_W-1:0] size,
    input  logic              bad,
    output logic [XLEN-1:0]   result
);

    always_comb begin
        result = '0;
        if (!bad) begin
            case (size)
                SZ_FULL:    result = word;
                SZ_WORD32:  result[31:0] = word[31:0];
                SZ_HALF16:  result[15:0] = word[15:0];
                SZ_BYTE_LO: result[7:0]  = word[7:0];
                SZ_BYTE_HI: result[7:0]  = word[15:8];
                default:    result = '0;
            endcase
        end
    end

endmodule

// File: rtl/subreg_regfile.sv
module subreg_regfile
    import subreg_pkg::*;
#(
    parameter int NUM_REGS       = 16,
    parameter int XLEN           = 64,
    parameter int HIGH_BYTE_REGS = 4,
    localparam int IDX_W         = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2:0]        wr_size,
    input  logic [XLEN-1:0]   wr_data,
    output logic              wr_illegal,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [2:0]        rd0_size,
    output logic [XLEN-1:0]   rd0_data,
    output logic              rd0_illegal,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [2:0]        rd1_size,
    output logic [XLEN-1:0]   rd1_data,
    output logic              rd1_illegal
);

    localparam int NUM_RD = 2;

    logic [XLEN-1:0] regs_d [NUM_REGS];
    logic [XLEN-1:0] regs_q [NUM_REGS];

    logic            wr_bad;
    logic [XLEN-1:0] wr_merged;

    subreg_legal_chk #(
        .NUM_REGS       (NUM_REGS),
        .HIGH_BYTE_REGS (HIGH_BYTE_REGS)
    ) u_wr_chk (
        .idx  (wr_idx),
        .size (wr_size),
        .bad  (wr_bad)
    );

    subreg_merge #(
        .XLEN (XLEN)
    ) u_merge (
        .old_val (regs_q[wr_idx]),
        .size    (wr_size),
        .data    (wr_data),
        .new_val (wr_merged)
    );

    assign wr_illegal = wr_en & wr_bad;

    // next-state process
    always_comb begin
        regs_d = regs_q;
        if (wr_en && !wr_bad) begin
            regs_d[wr_idx] = wr_merged;
        end
    end

    // state process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    // read ports
    logic [IDX_W-1:0]  rd_idx  [NUM_RD];
    logic [2:0]        rd_size [NUM_RD];
    logic [XLEN-1:0]   rd_res  [NUM_RD];
    logic              rd_bad  [NUM_RD];

    assign rd_idx[0]  = rd0_idx;
    assign rd_idx[1]  = rd1_idx;
    assign rd_size[0] = rd0_size;
    assign rd_size[1] = rd1_size;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        subreg_legal_chk #(
            .NUM_REGS       (NUM_REGS),
            .HIGH_BYTE_REGS (HIGH_BYTE_REGS)
        ) u_rd_chk (
            .idx  (rd_idx[p]),
            .size (rd_size[p]),
            .bad  (rd_bad[p])
        );

        subreg_slice #(
            .XLEN (XLEN)
        ) u_slice (
            .word   (regs_q[rd_idx[p]]),
            .size   (rd_size[p]),
            .bad    (rd_bad[p]),
            .result (rd_res[p])
        );
    end

    assign rd0_data    = rd_res[0];
    assign rd0_illegal = rd_bad[0];
    assign rd1_data    = rd_res[1];
    assign rd1_illegal = rd_bad[1];

    // assertions
    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_FULL) |=> regs_q[$past(wr_idx)] == $past(wr_data));

    p_upper_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_WORD32) |=>
            (regs_q[$past(wr_idx)][XLEN-1:32] == '0 &&
             regs_q[$past(wr_idx)][31:0] == $past(wr_data[31:0])));

    p_half_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_HALF16) |=>
            regs_q[$past(wr_idx)][XLEN-1:16] == $past(regs_q[wr_idx][XLEN-1:16]));

    p_lo_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE_LO) |=>
            (regs_q[$past(wr_idx)][XLEN-1:8] == $past(regs_q[wr_idx][XLEN-1:8]) &&
             regs_q[$past(wr_idx)][7:0] == $past(wr_data[7:0])));

    p_hi_place_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == SZ_BYTE_HI && !wr_illegal) |=>
            (regs_q[$past(wr_idx)][15:8] == $past(wr_data[7:0]) &&
             regs_q[$past(wr_idx)][7:0] == $past(regs_q[wr_idx][7:0])));

    p_illegal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_illegal |=> regs_q[$past(wr_idx)] == $past(regs_q[wr_idx]));

    p_rd0_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd0_illegal |-> rd0_data == '0);

    p_rd1_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_illegal |-> rd1_data == '0);

endmodule

// File: tb/subreg_regfile_tb.sv
module subreg_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [2:0]  wr_size = '0;
    logic [63:0] wr_data = '0;
    logic        wr_illegal;
    logic [3:0]  rd0_idx = '0;
    logic [2:0]  rd0_size = '0;
    logic [63:0] rd0_data;
    logic        rd0_illegal;
    logic [3:0]  rd1_idx = '0;
    logic [2:0]  rd1_size = '0;
    logic [63:0] rd1_data;
    logic        rd1_illegal;

    always #4 clk = ~clk;

    subreg_regfile dut_i (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_size (wr_size), .wr_data (wr_data),
        .wr_illegal (wr_illegal),
        .rd0_idx (rd0_idx), .rd0_size (rd0_size), .rd0_data (rd0_data), .rd0_illegal (rd0_illegal),
        .rd1_idx (rd1_idx), .rd1_size (rd1_size), .rd1_data (rd1_data), .rd1_illegal (rd1_illegal)
    );

    typedef struct {
        logic [63:0] r0;
        logic        i0;
        logic [63:0] r1;
        logic        i1;
        logic        wil;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [63:0] model [16];
    int          total = 0;
    int          bad = 0;
    bit          finished = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    function automatic bit is_bad(logic [3:0] idx, logic [2:0] sz);
        return (sz > 3'd4) || (sz == 3'd4 && idx >= 4'd4);
    endfunction

    function automatic logic [63:0] cut(logic [63:0] v, logic [3:0] idx, logic [2:0] sz);
        if (is_bad(idx, sz)) return 64'd0;
        case (sz)
            3'd0: return v;
            3'd1: return {32'd0, v[31:0]};
            3'd2: return {48'd0, v[15:0]};
            3'd3: return {56'd0, v[7:0]};
            default: return {56'd0, v[15:8]};
        endcase
    endfunction

    function automatic logic [63:0] put(logic [63:0] v, logic [2:0] sz, logic [63:0] d);
        case (sz)
            3'd0: return d;
            3'd1: return {32'd0, d[31:0]};
            3'd2: return {v[63:16], d[15:0]};
            3'd3: return {v[63:8], d[7:0]};
            default: return {v[63:16], d[7:0], v[7:0]};
        endcase
    endfunction

    task automatic step(input logic we, input logic [3:0] wi, input logic [2:0] ws,
                        input logic [63:0] wd, input logic [3:0] i0, input logic [2:0] s0,
                        input logic [3:0] i1, input logic [2:0] s1, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        wr_en = we; wr_idx = wi; wr_size = ws; wr_data = wd;
        rd0_idx = i0; rd0_size = s0; rd1_idx = i1; rd1_size = s1;
        e.r0  = cut(model[i0], i0, s0);
        e.i0  = is_bad(i0, s0);
        e.r1  = cut(model[i1], i1, s1);
        e.i1  = is_bad(i1, s1);
        e.wil = we && is_bad(wi, ws);
        e.tag = tag;
        sb_q.push_back(e);
        if (we && !is_bad(wi, ws)) model[wi] = put(model[wi], ws, wd);
    endtask

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(rd0_data, e.r0, "rd0_data", e.tag);
            chk({63'd0, rd0_illegal}, {63'd0, e.i0}, "rd0_illegal", e.tag);
            chk(rd1_data, e.r1, "rd1_data", e.tag);
            chk({63'd0, rd1_illegal}, {63'd0, e.i1}, "rd1_illegal", e.tag);
            chk({63'd0, wr_illegal}, {63'd0, e.wil}, "wr_illegal", e.tag);
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 64'd0;
        repeat (3) @(posedge clk);
        // R1: registers read zero while and after reset
        step(0, 0, 0, 0, 4'd0, 3'd0, 4'd15, 3'd0, "R1");
        #2 rst_n = 1'b1;
        step(0, 0, 0, 0, 4'd7, 3'd0, 4'd12, 3'd0, "R1");
        // R2: full write, same-cycle read returns old value
        step(1, 4'd3, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd3, 3'd0, 4'd3, 3'd1, "R2");
        step(0, 0, 0, 0, 4'd3, 3'd0, 4'd3, 3'd2, "R2");
        // R3: 32-bit write clears upper half
        step(1, 4'd3, 3'd1, 64'hAAAA_5555_1234_5678, 4'd3, 3'd0, 4'd0, 3'd0, "R3");
        step(0, 0, 0, 0, 4'd3, 3'd0, 4'd3, 3'd1, "R3");
        // R5 / R6: byte writes keep the rest
        step(1, 4'd0, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 3'd0, 4'd1, 3'd0, "R2");
        step(1, 4'd1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 3'd0, 4'd1, 3'd0, "R2");
        step(1, 4'd0, 3'd4, 64'h0000_0000_0000_0001, 4'd0, 3'd0, 4'd1, 3'd0, "R6");
        step(1, 4'd1, 3'd3, 64'h1234_5678_9ABC_DE01, 4'd0, 3'd0, 4'd0, 3'd4, "R6");
        step(0, 0, 0, 0, 4'd1, 3'd0, 4'd0, 3'd4, "R5");
        // R4: 16-bit write keeps 63:16
        step(1, 4'd9, 3'd0, 64'h0123_4567_89AB_CDEF, 4'd9, 3'd0, 4'd9, 3'd0, "R4");
        step(1, 4'd9, 3'd2, 64'h7777_7777_7777_BEEF, 4'd9, 3'd0, 4'd9, 3'd2, "R4");
        step(0, 0, 0, 0, 4'd9, 3'd0, 4'd9, 3'd1, "R4");
        // R7: refused writes, boundary index 3 versus 4
        step(1, 4'd9, 3'd4, 64'h55, 4'd9, 3'd0, 4'd9, 3'd0, "R7");
        step(1, 4'd4, 3'd4, 64'h66, 4'd4, 3'd0, 4'd3, 3'd4, "R7");
        step(1, 4'd2, 3'd5, 64'hDEAD, 4'd2, 3'd0, 4'd4, 3'd0, "R7");
        step(1, 4'd3, 3'd4, 64'hC3, 4'd9, 3'd0, 4'd2, 3'd0, "R6");
        step(1, 4'd15, 3'd7, 64'h1, 4'd3, 3'd0, 4'd15, 3'd0, "R7");
        // R8 / R9 / R10: read slices and refused reads
        step(0, 0, 0, 0, 4'd9, 3'd3, 4'd3, 3'd4, "R8");
        step(0, 0, 0, 0, 4'd9, 3'd4, 4'd15, 3'd4, "R9");
        step(0, 0, 0, 0, 4'd0, 3'd6, 4'd1, 3'd3, "R9");
        step(1, 4'd15, 3'd1, 64'hFFFF_FFFF_8000_0001, 4'd15, 3'd1, 4'd9, 3'd1, "R10");
        step(0, 0, 0, 0, 4'd15, 3'd0, 4'd15, 3'd3, "R10");
        // mixed pseudo-random phase
        for (int n = 0; n < 400; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            step(lfsr[0], lfsr[4:1], lfsr[7:5], {lfsr[31:0], lfsr[63:32]},
                 lfsr[11:8], lfsr[14:12], lfsr[18:15], lfsr[21:19], "R8");
        end
        step(0, 0, 0, 0, 4'd0, 3'd0, 4'd0, 3'd0, "R10");
        @(posedge clk);
        @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule